// File: doc/BRIEF.md
# Clock-Change Watchdog with Escalating Frequency Source

This block guards a change of the output frequency of a programmable clock source. Software first loads a timeout interval and arms the timer. It then writes a new target frequency code and, once the system runs stably at that code, disarms the timer again. If the disarm does not arrive before the interval runs out, the block drives an active-low system reset pulse of fixed width. The frequency code presented at its output then falls back to a safer source.

The escalation runs in two steps. After the first timeout the output code comes from a separately programmed fallback register. A timeout while running on the fallback code moves the output to the value taken from strap inputs right after power-up, and further timeouts leave it there. Writing a new target code while the timer is disarmed returns the block to the target source.

Time is measured in a single-cycle `tick` input. The length of one interval unit and the width of the reset pulse are parameters counted in ticks.

The control machine has three states. IDLE means the timer is disarmed. ARMED means the timer is counting. PULSE means the reset pulse is being driven. Its transitions are:

- ARM: from IDLE to ARMED on an enable write.
- DISARM: from ARMED to IDLE on a disable write.
- EXPIRE: from ARMED to PULSE on the tick that ends the interval.
- RELEASE: from PULSE to IDLE on the last tick of the pulse.

The source selector has three states: TARGET (00), FALLBACK (01) and STRAP (10). It moves from TARGET to FALLBACK and from FALLBACK to STRAP on EXPIRE, stays in STRAP on EXPIRE, and returns to TARGET on a target write in IDLE.

Top module: `wdt_freq_guard`

## Requirements
- R1: After reset `wd_rst_n` is 1, `freq_code` is 0 (the target register clears to 0), and the timer is disarmed.
- R2: A write with `wr_en`=1 uses `wr_sel` to pick the field. 0 writes the interval from `wr_data[5:0]`. 1 writes the control field, where `wr_data[0]`=1 arms the timer and 0 disarms it. 2 writes the target code from `wr_data[CODE_W-1:0]`. 3 writes the fallback code. In the TARGET source `freq_code` shows a new target code one cycle after the write.
- R3: Once armed, the (interval+1)*UNIT_TICKS-th tick after the arming write drives `wd_rst_n` low after the clock edge that samples it. Every earlier tick leaves it high.
- R4: `wd_rst_n` stays low for exactly PULSE_TICKS ticks. It returns high after the edge that samples the last of them.
- R5: The first timeout from the TARGET source switches `freq_code` to the fallback register. The switch happens in the same cycle that `wd_rst_n` falls.
- R6: A timeout from the FALLBACK source switches `freq_code` to the strap value. Further timeouts keep it there.
- R7: `strap_code` is captured on the first clock after reset is released. Later changes of `strap_code` have no effect.
- R8: Disarming clears the elapsed time. Re-arming starts a full new interval.
- R9: An arming write while the pulse is active is ignored. After the pulse the timer is disarmed and no further pulse follows, however many ticks arrive.
- R10: A target write while the timer is armed updates the register but does not change the source. A target write while disarmed selects the TARGET source.
- R11: A disarming write in the same cycle as the interval's final tick wins. No pulse is issued and the source is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle time-base pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Field select for the write |
| wr_data | input | 8 | Write data |
| strap_code | input | CODE_W | Strap frequency code, captured once after reset |
| wd_rst_n | output | 1 | Active-low system reset pulse |
| freq_code | output | CODE_W | Selected frequency code |

## Verification
Two functions can fall in the same cycle: software's disarm and the interval's final tick. The bench provokes this by delivering one tick less than the limit, then raising `tick` together with a control write that disarms. The expected outcome is that the disarm wins. `wd_rst_n` must stay high over a long run of later ticks, and `freq_code` must keep its source. The bench also tries an arming write in the middle of a pulse, and it arms the timer and disarms it after a random number of ticks with random gaps between them, either just before or at the limit. Each outcome is judged against a bench model of the source state.

// File: rtl/wdt_fg_pkg.sv
package wdt_fg_pkg;

    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_ARMED = 2'd1,
        WD_PULSE = 2'd2
    } wd_state_t;

    typedef enum logic [1:0] {
        SRC_TARGET   = 2'd0,
        SRC_FALLBACK = 2'd1,
        SRC_STRAP    = 2'd2
    } src_sel_t;

    localparam logic [1:0] SEL_IVL    = 2'd0;
    localparam logic [1:0] SEL_CTRL   = 2'd1;
    localparam logic [1:0] SEL_TARGET = 2'd2;
    localparam logic [1:0] SEL_FALLBK = 2'd3;

endpackage

// File: rtl/wdt_fg_regs.sv
module wdt_fg_regs
    import wdt_fg_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int IVL_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CODE_W-1:0] strap_code,
    output logic [IVL_W-1:0]  ivl_q,
    output logic [CODE_W-1:0] target_q,
    output logic [CODE_W-1:0] fallbk_q,
    output logic [CODE_W-1:0] strap_q,
    output logic              en_wr,
    output logic              dis_wr,
    output logic              tgt_wr
);

    logic strap_taken;
    logic unused_data;

    assign unused_data = ^wr_data;

    always_comb begin
        en_wr  = wr_en && (wr_sel == SEL_CTRL) && wr_data[0];
        dis_wr = wr_en && (wr_sel == SEL_CTRL) && !wr_data[0];
        tgt_wr = wr_en && (wr_sel == SEL_TARGET);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ivl_q    <= '0;
            target_q <= '0;
            fallbk_q <= '0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_IVL:    ivl_q    <= wr_data[IVL_W-1:0];
                SEL_TARGET: target_q <= wr_data[CODE_W-1:0];
                SEL_FALLBK: fallbk_q <= wr_data[CODE_W-1:0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strap_taken <= 1'b0;
            strap_q     <= '0;
        end else if (!strap_taken) begin
            strap_taken <= 1'b1;
            strap_q     <= strap_code;
        end
    end

    // R7
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strap_taken |=> $stable(strap_q));

endmodule

// File: rtl/wdt_fg_timer.sv
module wdt_fg_timer #(
    parameter int IVL_W      = 6,
    parameter int UNIT_TICKS = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [IVL_W-1:0] ivl,
    output logic             expire
);

    localparam int PRE_W = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(UNIT_TICKS - 1);

    logic [PRE_W-1:0] pre_cnt;
    logic [IVL_W-1:0] unit_cnt;
    logic             unit_done;

    assign unit_done = tick && (pre_cnt == PRE_LAST);
    assign expire    = run && unit_done && (unit_cnt == ivl);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt  <= '0;
            unit_cnt <= '0;
        end else if (!run) begin
            pre_cnt  <= '0;
            unit_cnt <= '0;
        end else if (unit_done) begin
            pre_cnt  <= '0;
            unit_cnt <= unit_cnt + 1'b1;
        end else if (tick) begin
            pre_cnt  <= pre_cnt + 1'b1;
        end
    end

    // R8
    fresh_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (pre_cnt == '0 && unit_cnt == '0));

endmodule

// File: rtl/wdt_fg_ctrl.sv
module wdt_fg_ctrl
    import wdt_fg_pkg::*;
#(
    parameter int PULSE_TICKS = 500
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      expire,
    input  logic      en_wr,
    input  logic      dis_wr,
    input  logic      tgt_wr,
    output wd_state_t state,
    output src_sel_t  src,
    output logic      run,
    output logic      wd_rst_n
);

    localparam int PW = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;
    localparam logic [PW-1:0] PULSE_LAST = PW'(PULSE_TICKS - 1);

    wd_state_t nxt;
    logic [PW-1:0] pulse_cnt;
    logic fire;

    assign fire = (state == WD_ARMED) && !dis_wr && expire;

    always_comb begin
        nxt = state;
        unique case (state)
            WD_IDLE:  if (en_wr) nxt = WD_ARMED;
            WD_ARMED: begin
                if (dis_wr)      nxt = WD_IDLE;
                else if (expire) nxt = WD_PULSE;
            end
            WD_PULSE: if (tick && pulse_cnt == PULSE_LAST) nxt = WD_IDLE;
            default:  nxt = WD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WD_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 pulse_cnt <= '0;
        else if (state != WD_PULSE) pulse_cnt <= '0;
        else if (tick)              pulse_cnt <= pulse_cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src <= SRC_TARGET;
        end else if (fire) begin
            unique case (src)
                SRC_TARGET:   src <= SRC_FALLBACK;
                SRC_FALLBACK: src <= SRC_STRAP;
                default:      src <= SRC_STRAP;
            endcase
        end else if (state == WD_IDLE && tgt_wr) begin
            src <= SRC_TARGET;
        end
    end

    always_comb begin
        run      = (state == WD_ARMED);
        wd_rst_n = (state != WD_PULSE);
    end

    // R11
    disarm_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_ARMED && dis_wr) |=> (state == WD_IDLE && wd_rst_n));
    // R3
    expire_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_ARMED && expire && !dis_wr) |=> !wd_rst_n);
    // R9
    no_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_PULSE) |=> (state != WD_ARMED));
    // R4
    release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_rst_n) |-> $past(tick));
    // R6
    strap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_STRAP && !(state == WD_IDLE && tgt_wr)) |=> (src == SRC_STRAP));
    // R10
    armed_keeps_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_ARMED && !expire) |=> $stable(src));

endmodule

// File: rtl/wdt_freq_guard.sv
module wdt_freq_guard
    import wdt_fg_pkg::*;
#(
    parameter int CODE_W      = 4,
    parameter int IVL_W       = 6,
    parameter int UNIT_TICKS  = 1000,
    parameter int PULSE_TICKS = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [7:0]        wr_data,
    input  logic [CODE_W-1:0] strap_code,
    output logic              wd_rst_n,
    output logic [CODE_W-1:0] freq_code
);

    localparam int DATA_W = 8;

    logic [IVL_W-1:0]  ivl_q;
    logic [CODE_W-1:0] target_q, fallbk_q, strap_q;
    logic              en_wr, dis_wr, tgt_wr, expire, run;
    wd_state_t         state;
    src_sel_t          src;

    wdt_fg_regs #(.CODE_W(CODE_W), .IVL_W(IVL_W), .DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .strap_code(strap_code), .ivl_q(ivl_q),
        .target_q(target_q), .fallbk_q(fallbk_q), .strap_q(strap_q),
        .en_wr(en_wr), .dis_wr(dis_wr), .tgt_wr(tgt_wr)
    );

    wdt_fg_timer #(.IVL_W(IVL_W), .UNIT_TICKS(UNIT_TICKS)) timer_i (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
        .ivl(ivl_q), .expire(expire)
    );

    wdt_fg_ctrl #(.PULSE_TICKS(PULSE_TICKS)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .expire(expire),
        .en_wr(en_wr), .dis_wr(dis_wr), .tgt_wr(tgt_wr),
        .state(state), .src(src), .run(run), .wd_rst_n(wd_rst_n)
    );

    always_comb begin
        unique case (src)
            SRC_TARGET:   freq_code = target_q;
            SRC_FALLBACK: freq_code = fallbk_q;
            SRC_STRAP:    freq_code = strap_q;
            default:      freq_code = strap_q;
        endcase
    end

    // R5
    pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_rst_n) |-> (src != SRC_TARGET));

endmodule

// File: tb/wdt_freq_guard_tb_top.sv
module wdt_freq_guard_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CODE_W     = 4;
    localparam int UNIT       = 3;
    localparam int PULSE      = 5;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [CODE_W-1:0] strap_code = 4'hA;
    logic wd_rst_n;
    logic [CODE_W-1:0] freq_code;

    int errs = 0, checks = 0, exp_src = 0;
    logic [CODE_W-1:0] tgt_m = '0, fb_m = '0, strap_m = 4'hA;

    wdt_freq_guard #(.CODE_W(CODE_W), .IVL_W(6), .UNIT_TICKS(UNIT),
                     .PULSE_TICKS(PULSE)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .strap_code(strap_code),
        .wd_rst_n(wd_rst_n), .freq_code(freq_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int limit(int ivl);
        return (ivl + 1) * UNIT;
    endfunction

    function automatic logic [CODE_W-1:0] exp_freq();
        case (exp_src)
            0:       return tgt_m;
            1:       return fb_m;
            default: return strap_m;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write(logic [1:0] sel, logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(int n, bit gaps);
        for (int i = 0; i < n; i++) begin
            if (gaps && ($urandom % 3 == 0)) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic expire_run(int ivl, string req, bit gaps);
        write(2'd0, 8'(ivl));
        write(2'd1, 8'd1);
        ticks(limit(ivl) - 1, gaps);
        check("R3", int'(wd_rst_n), 1);
        ticks(1, gaps);
        check("R3", int'(wd_rst_n), 0);
        exp_src = (exp_src < 2) ? exp_src + 1 : 2;
        check(req, int'(freq_code), int'(exp_freq()));
        ticks(PULSE - 1, gaps);
        check("R4", int'(wd_rst_n), 0);
        ticks(1, gaps);
        check("R4", int'(wd_rst_n), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errs++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        strap_code = 4'h5;
        // R1 reset state
        check("R1", int'(wd_rst_n), 1);
        check("R1", int'(freq_code), 0);
        // R2 field writes
        write(2'd2, 8'h03); tgt_m = 4'h3;
        check("R2", int'(freq_code), 3);
        write(2'd3, 8'h09); fb_m = 4'h9;
        check("R2", int'(freq_code), 3);
        // R3 R4 R5 first timeout
        expire_run(2, "R5", 1'b0);
        // R10 target write while armed keeps source
        write(2'd0, 8'd2);
        write(2'd1, 8'd1);
        write(2'd2, 8'h06); tgt_m = 4'h6;
        check("R10", int'(freq_code), int'(fb_m));
        write(2'd1, 8'd0);
        // R6 R7 escalation to strap and staying there
        expire_run(1, "R6", 1'b0);
        check("R7", int'(freq_code), 4'hA);
        expire_run(0, "R6", 1'b0);
        // R9 arming write during pulse ignored
        write(2'd0, 8'd0);
        write(2'd1, 8'd1);
        ticks(limit(0), 1'b0);
        check("R9", int'(wd_rst_n), 0);
        write(2'd1, 8'd1);
        ticks(PULSE, 1'b0);
        check("R9", int'(wd_rst_n), 1);
        ticks(limit(0) * 4, 1'b0);
        check("R9", int'(wd_rst_n), 1);
        // R10 target write in idle restores target source
        write(2'd2, 8'h07); tgt_m = 4'h7; exp_src = 0;
        check("R10", int'(freq_code), 7);
        // R8 disarm clears elapsed time
        write(2'd0, 8'd1);
        write(2'd1, 8'd1);
        ticks(4, 1'b0);
        write(2'd1, 8'd0);
        write(2'd1, 8'd1);
        ticks(limit(1) - 1, 1'b0);
        check("R8", int'(wd_rst_n), 1);
        ticks(1, 1'b0);
        check("R8", int'(wd_rst_n), 0);
        exp_src = 1;
        ticks(PULSE, 1'b0);
        // R11 disarm on the final tick wins
        write(2'd2, 8'h02); tgt_m = 4'h2; exp_src = 0;
        write(2'd1, 8'd1);
        ticks(limit(1) - 1, 1'b0);
        tick = 1'b1; wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'd0;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        check("R11", int'(wd_rst_n), 1);
        ticks(20, 1'b0);
        check("R11", int'(wd_rst_n), 1);
        check("R11", int'(freq_code), 2);
        // random mix
        for (int it = 0; it < 30; it++) begin
            int ivl, k;
            if ($urandom % 2 == 1) begin
                tgt_m = 4'($urandom);
                write(2'd2, 8'(tgt_m));
                exp_src = 0;
            end
            if ($urandom % 3 == 0) begin
                fb_m = 4'($urandom);
                write(2'd3, 8'(fb_m));
            end
            ivl = $urandom % 3;
            k = $urandom % (limit(ivl) + 2);
            if (k < limit(ivl)) begin
                write(2'd0, 8'(ivl));
                write(2'd1, 8'd1);
                ticks(k, 1'b1);
                write(2'd1, 8'd0);
                check("R8", int'(wd_rst_n), 1);
                check("R2", int'(freq_code), int'(exp_freq()));
            end else begin
                expire_run(ivl, "R6", 1'b1);
            end
        end
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule